// File: doc/BRIEF.md
# Hart Timer and Software-Interrupt Unit

This block is a register-mapped peripheral that gives each hart of a small multi-hart cluster two interrupt sources. The first is a timer. All harts share one 64-bit counter that runs freely, and each hart has its own 64-bit compare value. A hart's timer line is high while the shared counter has reached or passed that hart's compare value. The second source is a software interrupt that any bus master can set or clear for any hart. Software uses it to signal between processors.

The block sits on a plain 32-bit register bus. Each 64-bit quantity is reached as two 32-bit words: the low word at the base address and the high word at base+4. To read the counter consistently, software reads the high word, then the low word, then the high word again, and repeats if the two high reads differ. To schedule an event, software reads the counter, adds a delta and writes the sum into the hart's compare register. A tick-enable input sets the counter rate: the counter advances once on each clock cycle in which the input is high.

Top module: `hart_timer_swi`

## Requirements
- R1: After reset the counter reads 0, every compare register reads all-ones in both halves, every software-interrupt bit is 0, both interrupt vectors are low and `bus_ready` is low.
- R2: The counter adds exactly one on every cycle with `tick_en` high and no bus write, and holds otherwise. A carry out of the low word propagates into the high word.
- R3: The counter's low word (0xBFF8) and high word (0xBFFC) are written independently, honouring byte strobes. A bus write takes precedence over an increment in the same cycle.
- R4: Word addresses decode as follows: hart h's software-interrupt word is at 4·h; hart h's compare low word is at 0x4000+8·h and its high word at 0x4000+8·h+4. Address bits [1:0] are ignored.
- R5: A write to a hart's software-interrupt word with strobe bit 0 set loads data bit 0 into that hart's software-interrupt bit, which drives `soft_irq[h]`. Bits 31:1 read as zero. A write with strobe bit 0 clear changes nothing.
- R6: `timer_irq[h]` equals the registered result of the unsigned comparison counter ≥ compare[h], with one cycle of lag. It stays high until the counter or the compare value changes so that the comparison becomes false.
- R7: Reads of any unmapped address return 0. Writes to unmapped addresses change no state.
- R8: `bus_ready` is high in the cycle after each cycle with `bus_req` high, and low otherwise. `bus_rdata` in that cycle holds the addressed word as it was before any write carried by the same request.
- R9: A write to a compare word replaces only the bytes whose strobe bits are set.
- R10: Writes that address one hart's registers leave every other hart's compare value, software bit and interrupt lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advances on each cycle this is high |
| bus_req | input | 1 | Bus access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for writes |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Access completed, one cycle after request |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt, level |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt, level |

## Verification
The bench builds the block with NUM_HARTS=4 and ADDR_W=16. With four harts the hart index appears in both decoded address fields, so the bench can probe the first word past the last software-interrupt word (0x0010) and the first word past the last compare doubleword (0x4020), both of which must read zero. Four harts also make it possible to check that a hart's neighbours stay untouched. The 64-bit counter is preloaded just below the 32-bit carry point to exercise propagation into the high word. Random counter/compare pairs, some biased to be equal or within a few counts of each other, test the unsigned comparison on both sides of equality.

// File: rtl/hts_pkg.sv
`timescale 1ns/1ps
package hts_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned STRB_W     = BUS_W / 8;
  localparam int unsigned CNT_W      = 2 * BUS_W;
  localparam int unsigned SWI_BASE   = 32'h0000_0000;
  localparam int unsigned CMP_BASE   = 32'h0000_4000;
  localparam int unsigned CNT_BASE   = 32'h0000_BFF8;
  localparam int unsigned SWI_STRIDE = 4;
  localparam int unsigned CMP_STRIDE = 8;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_SWI,
    RGN_CMP_LO,
    RGN_CMP_HI,
    RGN_CNT_LO,
    RGN_CNT_HI
  } rgn_e;

  // Byte-lane merge of a new word into an old one.
  function automatic logic [BUS_W-1:0] lane_merge(
    input logic [BUS_W-1:0]  old_w,
    input logic [BUS_W-1:0]  new_w,
    input logic [STRB_W-1:0] strb
  );
    logic [BUS_W-1:0] r;
    for (int b = 0; b < int'(STRB_W); b++) begin
      r[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/hts_addr_decode.sv
`timescale 1ns/1ps
module hts_addr_decode
  import hts_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16,
  localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [HART_W-1:0] hart
);
  localparam logic [ADDR_W-1:0] SWI_LO   = ADDR_W'(SWI_BASE);
  localparam logic [ADDR_W-1:0] SWI_SPAN = ADDR_W'(SWI_STRIDE * NUM_HARTS);
  localparam logic [ADDR_W-1:0] CMP_LO   = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(CMP_STRIDE * NUM_HARTS);
  localparam logic [ADDR_W-1:0] CNT_LOW  = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] CNT_HIGH = ADDR_W'(CNT_BASE + 4);

  logic [ADDR_W-1:0] word_a;
  logic [ADDR_W-1:0] swi_off;
  logic [ADDR_W-1:0] cmp_off;

  assign word_a  = {addr[ADDR_W-1:2], 2'b00};
  assign swi_off = word_a - SWI_LO;
  assign cmp_off = word_a - CMP_LO;

  always_comb begin
    rgn  = RGN_NONE;
    hart = '0;
    if (swi_off < SWI_SPAN) begin
      rgn  = RGN_SWI;
      hart = HART_W'(swi_off >> 2);
    end else if (cmp_off < CMP_SPAN) begin
      rgn  = cmp_off[2] ? RGN_CMP_HI : RGN_CMP_LO;
      hart = HART_W'(cmp_off >> 3);
    end else if (word_a == CNT_LOW) begin
      rgn  = RGN_CNT_LO;
    end else if (word_a == CNT_HIGH) begin
      rgn  = RGN_CNT_HI;
    end
  end
endmodule

// File: rtl/hts_time_counter.sv
`timescale 1ns/1ps
module hts_time_counter
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [STRB_W-1:0] strb,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // A bus write wins over the increment in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[BUS_W-1:0]     <= lane_merge(cnt_q[BUS_W-1:0], wdata, strb);
      if (wr_hi) cnt_q[CNT_W-1:BUS_W] <= lane_merge(cnt_q[CNT_W-1:BUS_W], wdata, strb);
    end else if (tick_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hts_hart_slice.sv
`timescale 1ns/1ps
module hts_hart_slice
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_swi,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [STRB_W-1:0] strb,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              swi_o,
  output logic              tirq_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             swi_q;
  logic             tirq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
    end else begin
      if (wr_cmp_lo) cmp_q[BUS_W-1:0]     <= lane_merge(cmp_q[BUS_W-1:0], wdata, strb);
      if (wr_cmp_hi) cmp_q[CNT_W-1:BUS_W] <= lane_merge(cmp_q[CNT_W-1:BUS_W], wdata, strb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swi_q <= 1'b0;
    end else if (wr_swi && strb[0]) begin
      swi_q <= wdata[0];
    end
  end

  // Registered unsigned compare: one cycle of lag, clean output.
  always_ff @(posedge clk) begin
    if (rst) tirq_q <= 1'b0;
    else     tirq_q <= (cnt >= cmp_q);
  end

  assign cmp_o  = cmp_q;
  assign swi_o  = swi_q;
  assign tirq_o = tirq_q;
endmodule

// File: rtl/hart_timer_swi.sv
`timescale 1ns/1ps
module hart_timer_swi
  import hts_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_be,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ready,
  output logic [NUM_HARTS-1:0] timer_irq,
  output logic [NUM_HARTS-1:0] soft_irq
);
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  rgn_e                      rgn;
  logic [HART_W-1:0]         hart;
  logic                      wr_any;
  logic [CNT_W-1:0]          cnt_q;
  logic [CNT_W*NUM_HARTS-1:0] cmp_flat;
  logic [BUS_W-1:0]          rd_next;
  logic [BUS_W-1:0]          rdata_q;
  logic                      ready_q;

  assign wr_any = bus_req && bus_we;

  hts_addr_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) dec_i (
    .addr (bus_addr),
    .rgn  (rgn),
    .hart (hart)
  );

  hts_time_counter cnt_i (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_lo   (wr_any && (rgn == RGN_CNT_LO)),
    .wr_hi   (wr_any && (rgn == RGN_CNT_HI)),
    .wdata   (bus_wdata),
    .strb    (bus_be),
    .cnt_o   (cnt_q)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic sel;
    assign sel = wr_any && (hart == HART_W'(h));
    hts_hart_slice slice_i (
      .clk       (clk),
      .rst       (rst),
      .cnt       (cnt_q),
      .wr_swi    (sel && (rgn == RGN_SWI)),
      .wr_cmp_lo (sel && (rgn == RGN_CMP_LO)),
      .wr_cmp_hi (sel && (rgn == RGN_CMP_HI)),
      .wdata     (bus_wdata),
      .strb      (bus_be),
      .cmp_o     (cmp_flat[CNT_W*h +: CNT_W]),
      .swi_o     (soft_irq[h]),
      .tirq_o    (timer_irq[h])
    );
  end

  always_comb begin
    rd_next = '0;
    unique case (rgn)
      RGN_SWI:    rd_next = {{(BUS_W-1){1'b0}}, soft_irq[hart]};
      RGN_CMP_LO: rd_next = cmp_flat[CNT_W*hart +: BUS_W];
      RGN_CMP_HI: rd_next = cmp_flat[CNT_W*hart + BUS_W +: BUS_W];
      RGN_CNT_LO: rd_next = cnt_q[BUS_W-1:0];
      RGN_CNT_HI: rd_next = cnt_q[CNT_W-1:BUS_W];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= bus_req;
      if (bus_req) rdata_q <= rd_next;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_ready = ready_q;
endmodule

// File: rtl/hts_checker.sv
`timescale 1ns/1ps
module hts_checker #(
  parameter int NUM_HARTS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick_en,
  input logic                    bus_req,
  input logic                    bus_we,
  input logic                    bus_ready,
  input logic [63:0]             cnt,
  input logic [64*NUM_HARTS-1:0] cmp_flat,
  input logic [NUM_HARTS-1:0]    timer_irq,
  input logic [NUM_HARTS-1:0]    soft_irq
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cnt == 64'd0 && soft_irq == '0 && timer_irq == '0 && !bus_ready));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !(bus_req && bus_we)) |=> (cnt == $past(cnt) + 64'd1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !(bus_req && bus_we)) |=> $stable(cnt));

  p_swi_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> $stable(soft_irq));

  p_ready_follows_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ready);

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ready);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
    p_timer_level_r6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (timer_irq[h] == ($past(cnt) >= $past(cmp_flat[64*h +: 64]))));
  end
endmodule

bind hart_timer_swi hts_checker #(.NUM_HARTS(NUM_HARTS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_ready (bus_ready),
  .cnt       (cnt_q),
  .cmp_flat  (cmp_flat),
  .timer_irq (timer_irq),
  .soft_irq  (soft_irq)
);

// File: tb/hart_timer_swi_tb_top.sv
`timescale 1ns/1ps
module hart_timer_swi_tb_top;
  localparam int NH = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_rdata;
  logic          bus_ready;
  logic [NH-1:0] timer_irq;
  logic [NH-1:0] soft_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hart_timer_swi #(.NUM_HARTS(NH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .timer_irq(timer_irq), .soft_irq(soft_irq)
  );

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = s[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  function automatic logic exp_irq(input logic [63:0] c, input logic [63:0] m);
    return c >= m;
  endfunction

  function automatic logic [15:0] cmp_addr(input int h, input bit hi);
    return 16'h4000 + 16'(8 * h) + (hi ? 16'd4 : 16'd0);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Starts and ends on a falling edge.
  task automatic xfer(input logic [15:0] a, input logic we, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd);
    logic rdy;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    rd = bus_rdata; rdy = bus_ready;
    bus_req = 1'b0; bus_we = 1'b0;
    check(rdy == 1'b1, "R8 ready", 64'(rdy), 64'd1);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] dummy;
    xfer(a, 1'b1, d, be, dummy);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    xfer(a, 1'b0, 32'h0, 4'h0, v);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_cnt(input logic [63:0] v);
    wr(16'hBFF8, v[31:0], 4'hF);
    wr(16'hBFFC, v[63:32], 4'hF);
  endtask

  task automatic set_cmp(input int h, input logic [63:0] v);
    wr(cmp_addr(h, 1'b1), v[63:32], 4'hF);
    wr(cmp_addr(h, 1'b0), v[31:0], 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] c, m;
    int h;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(bus_ready == 1'b0, "R1 ready", 64'(bus_ready), 0);
    check(timer_irq == '0 && soft_irq == '0, "R1 irqs", {timer_irq, soft_irq}, 0);
    rd(16'hBFF8, v); check(v == 0, "R1 cnt lo", v, 0);
    rd(16'hBFFC, v); check(v == 0, "R1 cnt hi", v, 0);
    for (int i = 0; i < NH; i++) begin
      rd(cmp_addr(i, 0), v); check(v == 32'hFFFF_FFFF, "R1 R4 cmp lo", v, 32'hFFFF_FFFF);
      rd(cmp_addr(i, 1), v); check(v == 32'hFFFF_FFFF, "R1 R4 cmp hi", v, 32'hFFFF_FFFF);
      rd(16'(4 * i), v);     check(v == 0, "R1 swi", v, 0);
    end
    @(negedge clk);
    check(bus_ready == 1'b0, "R8 ready idle", 64'(bus_ready), 0);

    // R2 counting and holding
    set_cnt(64'd0);
    ticks(10);
    repeat (3) @(negedge clk);
    rd(16'hBFF8, v); check(v == 32'd10, "R2 count", v, 10);
    set_cnt(64'h0000_0001_FFFF_FFFC);
    ticks(6);
    rd(16'hBFF8, v); check(v == 32'd2, "R2 carry lo", v, 2);
    rd(16'hBFFC, v); check(v == 32'd2, "R2 carry hi", v, 2);

    // R3 byte strobes and write precedence
    set_cnt(64'h1111_2222_3333_4444);
    wr(16'hBFF8, 32'hAABB_CCDD, 4'b0010);
    rd(16'hBFF8, v); check(v == 32'h3333_CC44, "R3 strobe lo", v, 32'h3333_CC44);
    rd(16'hBFFC, v); check(v == 32'h1111_2222, "R3 hi kept", v, 32'h1111_2222);
    tick_en = 1'b1;
    wr(16'hBFF9, 32'h0000_0500, 4'hF);
    tick_en = 1'b0;
    rd(16'hBFF8, v); check(v == 32'h500, "R3 write wins", v, 32'h500);

    // R5 software interrupts, R8 read-before-write
    begin
      logic [31:0] old;
      xfer(16'h0008, 1'b1, 32'hFFFF_FFFF, 4'hF, old);
      check(old == 0, "R8 old value", old, 0);
    end
    rd(16'h0008, v); check(v == 32'd1, "R5 swi read", v, 1);
    check(soft_irq == 4'b0100, "R5 R10 swi line", 64'(soft_irq), 4'b0100);
    wr(16'h0008, 32'h0, 4'b1110);
    check(soft_irq == 4'b0100, "R5 strobe0 clear ignored", 64'(soft_irq), 4'b0100);
    wr(16'h0008, 32'hFFFF_FFFE, 4'hF);
    check(soft_irq == 4'b0000, "R5 clear", 64'(soft_irq), 0);

    // R9 compare byte strobes
    wr(cmp_addr(1, 0), 32'h1234_5678, 4'b0101);
    rd(cmp_addr(1, 0), v);
    check(v == merge(32'hFFFF_FFFF, 32'h1234_5678, 4'b0101), "R9 cmp strobe", v, 32'hFF34_FF78);

    // R6 timer level and R10 isolation
    set_cnt(64'd100);
    set_cmp(3, 64'd100);
    @(negedge clk);
    check(timer_irq == 4'b1000, "R6 R10 equal fires", 64'(timer_irq), 4'b1000);
    wr(cmp_addr(3, 0), 32'd101, 4'hF);
    @(negedge clk);
    check(timer_irq == 4'b0000, "R6 clears on larger cmp", 64'(timer_irq), 0);
    ticks(1);
    @(negedge clk);
    check(timer_irq == 4'b1000, "R6 fires after tick", 64'(timer_irq), 4'b1000);
    set_cmp(3, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7 unmapped accesses
    wr(16'h0010, 32'hFFFF_FFFF, 4'hF);
    wr(16'h4020, 32'h0, 4'hF);
    check(soft_irq == 0, "R7 write ignored", 64'(soft_irq), 0);
    rd(16'h0010, v); check(v == 0, "R7 past swi", v, 0);
    rd(16'h4020, v); check(v == 0, "R7 past cmp", v, 0);
    rd(16'h8000, v); check(v == 0, "R7 gap", v, 0);
    rd(16'hBFF4, v); check(v == 0, "R7 below cnt", v, 0);
    rd(cmp_addr(0, 0), v); check(v == 32'hFFFF_FFFF, "R7 cmp0 untouched", v, 32'hFFFF_FFFF);

    // Random compare/counter pairs
    for (int it = 0; it < 40; it++) begin
      int mode;
      h = int'($urandom % NH);
      c = {$urandom, $urandom};
      mode = int'($urandom % 3);
      if (mode == 0)      m = {$urandom, $urandom};
      else if (mode == 1) m = c;
      else                m = c + 64'($signed(int'($urandom % 7) - 3));
      set_cnt(c);
      set_cmp(h, m);
      @(negedge clk);
      check(timer_irq[h] == exp_irq(c, m), "R6 random compare", 64'(timer_irq[h]), 64'(exp_irq(c, m)));
      rd(cmp_addr(h, 1), v); check(v == m[63:32], "R4 random cmp hi", v, m[63:32]);
      set_cmp(h, 64'hFFFF_FFFF_FFFF_FFFF);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule